// File: doc/BRIEF.md
# Dispatch steering unit

The block sits between rename and the out-of-order back end. Each cycle rename presents a group of instruction slots. The unit decides, for every slot, where that instruction goes. A load is reserved in the load section of the load/store queue and also joins the issue queue for ordinary wakeup. A store is reserved in the store section and parked in the issue queue's non-speculative area. Any other non-speculative instruction is parked in the same area. Stores and non-speculative instructions are marked ready to commit when they are dispatched, because they execute only when commit sends their sequence number back. Nops and slots that are already squashed are consumed and take no queue entry.

A group is accepted whole or held whole. The unit tracks how full the issue queue is, from the entries it inserts and the entries the queue reports as leaving. When the group needs more entries than are free, or while the back end is squashing, the group is held and a block signal tells rename to keep it. The number of free entries is reported to rename every cycle. Commit feedback (store commit, load commit, non-speculative release) passes through a one-cycle register stage toward the queues.

Top module: `dispatch_steer`

## Requirements
- R1: Slots are scanned upward from slot 0; the first slot whose valid bit is low ends the group, and no slot above it produces any strobe, even if its own valid bit is high.
- R2: While `squashing` is high no strobe is raised, and `rn_block` is high whenever slot 0 is valid.
- R3: A live slot with its squashed flag set raises no strobe and uses no issue-queue entry.
- R4: A live load (load flag has priority over every other class flag) raises both `ldq_put` and `iq_put` for its slot.
- R5: A live store that is not a load raises `stq_put`, `iq_put_ns` and `can_commit` for its slot, and nothing else.
- R6: A live non-speculative instruction that is neither load nor store raises `iq_put_ns` and `can_commit` for its slot only.
- R7: A live nop that is not a load, store or non-speculative instruction raises no strobe and uses no issue-queue entry.
- R8: Any other live instruction raises `iq_put` for its slot only.
- R9: `iq_free` equals IQ_DEPTH minus the occupancy; on each clock the occupancy first loses `iq_drain` entries (at most the current occupancy) and then gains one entry per accepted slot that raised `iq_put` or `iq_put_ns`. After reset `iq_free` is IQ_DEPTH.
- R10: When the number of issue-queue entries the group needs exceeds `iq_free`, no strobe is raised and `rn_block` is high; with slot 0 invalid `rn_block` is low.
- R11: One cycle after `cm_store` is high, `lsq_store_commit` is high and `lsq_commit_seq` carries that cycle's `cm_done_seq`; `lsq_load_commit` follows `cm_load` the same way only when `cm_store` was low.
- R12: One cycle after `cm_ns_seq` is non-zero, `iq_ns_release` is high and `iq_ns_release_seq` carries that number; a zero value gives no release.
- R13: Bit i of every strobe vector belongs to slot i, so the receiving queue sees the group in program order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rn_valid | input | SLOTS | Slot holds an instruction |
| rn_squashed | input | SLOTS | Slot instruction already squashed |
| rn_load | input | SLOTS | Slot instruction is a load |
| rn_store | input | SLOTS | Slot instruction is a store |
| rn_nonspec | input | SLOTS | Slot instruction must run non-speculatively |
| rn_nop | input | SLOTS | Slot instruction is a nop |
| squashing | input | 1 | Back end is squashing; dispatch nothing |
| iq_drain | input | CNT_W | Issue-queue entries freed this cycle |
| cm_store | input | 1 | Commit retired stores |
| cm_load | input | 1 | Commit retired loads |
| cm_done_seq | input | SEQ_W | Sequence number of the commit boundary |
| cm_ns_seq | input | SEQ_W | Non-speculative release number, zero for none |
| iq_put | output | SLOTS | Normal issue-queue insert per slot |
| iq_put_ns | output | SLOTS | Non-speculative issue-queue insert per slot |
| ldq_put | output | SLOTS | Load-section insert per slot |
| stq_put | output | SLOTS | Store-section insert per slot |
| can_commit | output | SLOTS | Mark slot instruction ready to commit |
| rn_block | output | 1 | Group held; rename keeps it |
| iq_free | output | CNT_W | Free issue-queue entries |
| lsq_store_commit | output | 1 | Release stores up to `lsq_commit_seq` |
| lsq_load_commit | output | 1 | Release loads up to `lsq_commit_seq` |
| lsq_commit_seq | output | SEQ_W | Commit boundary sequence number |
| iq_ns_release | output | 1 | Schedule a parked instruction |
| iq_ns_release_seq | output | SEQ_W | Sequence number to schedule |

## Verification
The bench builds the unit with four slots, an eight-entry issue queue and six-bit sequence numbers. With only eight entries, two full groups fill the queue, so the held-group path and the zero-free case come up often under random traffic, and drain requests larger than the occupancy exercise the clamp. Four slots leave room for a gap in the middle of a group and for all four instruction classes in one group.

// File: rtl/dispatch_steer_pkg.sv
package dispatch_steer_pkg;

  // Destination decision for one dispatch slot.
  typedef struct packed {
    logic to_iq;     // ordinary issue-queue entry
    logic to_iq_ns;  // parked non-speculative entry
    logic to_ldq;    // load section reservation
    logic to_stq;    // store section reservation
    logic cc;        // ready-to-commit mark
    logic uses_iq;   // consumes one issue-queue entry
  } route_t;

endpackage

// File: rtl/steer_slot.sv
module steer_slot
  import dispatch_steer_pkg::*;
(
  input  logic   live,
  input  logic   squashed,
  input  logic   is_load,
  input  logic   is_store,
  input  logic   is_nonspec,
  input  logic   is_nop,
  output route_t route
);

  always_comb begin
    route = '0;
    if (live && !squashed) begin
      if (is_load) begin
        route.to_ldq = 1'b1;
        route.to_iq  = 1'b1;
      end else if (is_store) begin
        route.to_stq   = 1'b1;
        route.to_iq_ns = 1'b1;
        route.cc       = 1'b1;
      end else if (is_nonspec) begin
        route.to_iq_ns = 1'b1;
        route.cc       = 1'b1;
      end else if (!is_nop) begin
        route.to_iq = 1'b1;
      end
      route.uses_iq = route.to_iq | route.to_iq_ns;
    end
  end

endmodule

// File: rtl/iq_credit.sv
module iq_credit #(
  parameter int DEPTH = 16,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic [CNT_W-1:0] add,
  input  logic [CNT_W-1:0] drain,
  output logic [CNT_W-1:0] free
);

  logic [CNT_W-1:0] occ_q, occ_d, taken;
  logic             occ_en;

  always_comb begin
    taken  = (drain > occ_q) ? occ_q : drain;
    occ_d  = occ_q - taken + add;
    occ_en = (add != '0) || (drain != '0);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     occ_q <= '0;
    else if (occ_en) occ_q <= occ_d;
  end

  assign free = CNT_W'(DEPTH) - occ_q;

endmodule

// File: rtl/commit_relay.sv
module commit_relay #(
  parameter int SEQ_W = 8
) (
  input  logic             clk,
  input  logic             srst_n,
  input  logic             st_in,
  input  logic             ld_in,
  input  logic [SEQ_W-1:0] done_seq,
  input  logic [SEQ_W-1:0] ns_seq_in,
  output logic             rel_st,
  output logic             rel_ld,
  output logic [SEQ_W-1:0] rel_seq,
  output logic             ns_go,
  output logic [SEQ_W-1:0] ns_seq
);

  logic rel_st_d, rel_ld_d, ns_go_d, seq_en;

  always_comb begin
    rel_st_d = st_in;
    rel_ld_d = ld_in && !st_in;
    seq_en   = st_in || ld_in;
    ns_go_d  = (ns_seq_in != '0);
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rel_st <= 1'b0;
      rel_ld <= 1'b0;
      ns_go  <= 1'b0;
    end else begin
      rel_st <= rel_st_d;
      rel_ld <= rel_ld_d;
      ns_go  <= ns_go_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     rel_seq <= '0;
    else if (seq_en) rel_seq <= done_seq;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)      ns_seq <= '0;
    else if (ns_go_d) ns_seq <= ns_seq_in;
  end

endmodule

// File: rtl/dispatch_steer.sv
module dispatch_steer
  import dispatch_steer_pkg::*;
#(
  parameter int SLOTS    = 4,
  parameter int IQ_DEPTH = 16,
  parameter int SEQ_W    = 8,
  localparam int CNT_W   = $clog2(IQ_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SLOTS-1:0] rn_valid,
  input  logic [SLOTS-1:0] rn_squashed,
  input  logic [SLOTS-1:0] rn_load,
  input  logic [SLOTS-1:0] rn_store,
  input  logic [SLOTS-1:0] rn_nonspec,
  input  logic [SLOTS-1:0] rn_nop,
  input  logic             squashing,
  input  logic [CNT_W-1:0] iq_drain,
  input  logic             cm_store,
  input  logic             cm_load,
  input  logic [SEQ_W-1:0] cm_done_seq,
  input  logic [SEQ_W-1:0] cm_ns_seq,
  output logic [SLOTS-1:0] iq_put,
  output logic [SLOTS-1:0] iq_put_ns,
  output logic [SLOTS-1:0] ldq_put,
  output logic [SLOTS-1:0] stq_put,
  output logic [SLOTS-1:0] can_commit,
  output logic             rn_block,
  output logic [CNT_W-1:0] iq_free,
  output logic             lsq_store_commit,
  output logic             lsq_load_commit,
  output logic [SEQ_W-1:0] lsq_commit_seq,
  output logic             iq_ns_release,
  output logic [SEQ_W-1:0] iq_ns_release_seq
);

  // Reset: asserted at once, released through two flops.
  logic rst_m, srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rst_m  <= 1'b1;
      srst_n <= rst_m;
    end
  end

  // Group scan: a slot is live only if every slot below it is valid.
  logic   [SLOTS-1:0] live;
  route_t             routes [SLOTS];

  assign live[0] = rn_valid[0];
  for (genvar g = 1; g < SLOTS; g++) begin : g_scan
    assign live[g] = live[g-1] & rn_valid[g];
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    steer_slot u_slot (
      .live       (live[g]),
      .squashed   (rn_squashed[g]),
      .is_load    (rn_load[g]),
      .is_store   (rn_store[g]),
      .is_nonspec (rn_nonspec[g]),
      .is_nop     (rn_nop[g]),
      .route      (routes[g])
    );
  end

  // Entries the whole group needs, and the accept decision.
  logic [CNT_W-1:0] need, credit_add;
  logic             accept;

  always_comb begin
    need = '0;
    for (int i = 0; i < SLOTS; i++) need = need + CNT_W'(routes[i].uses_iq);
    accept     = !squashing && (need <= iq_free);
    credit_add = accept ? need : '0;
    rn_block   = live[0] && !accept;
  end

  always_comb begin
    for (int i = 0; i < SLOTS; i++) begin
      iq_put[i]     = accept & routes[i].to_iq;
      iq_put_ns[i]  = accept & routes[i].to_iq_ns;
      ldq_put[i]    = accept & routes[i].to_ldq;
      stq_put[i]    = accept & routes[i].to_stq;
      can_commit[i] = accept & routes[i].cc;
    end
  end

  iq_credit #(.DEPTH(IQ_DEPTH), .CNT_W(CNT_W)) u_credit (
    .clk    (clk),
    .srst_n (srst_n),
    .add    (credit_add),
    .drain  (iq_drain),
    .free   (iq_free)
  );

  commit_relay #(.SEQ_W(SEQ_W)) u_relay (
    .clk       (clk),
    .srst_n    (srst_n),
    .st_in     (cm_store),
    .ld_in     (cm_load),
    .done_seq  (cm_done_seq),
    .ns_seq_in (cm_ns_seq),
    .rel_st    (lsq_store_commit),
    .rel_ld    (lsq_load_commit),
    .rel_seq   (lsq_commit_seq),
    .ns_go     (iq_ns_release),
    .ns_seq    (iq_ns_release_seq)
  );

endmodule

// File: rtl/dispatch_steer_checks.sv
module dispatch_steer_checks #(
  parameter int SLOTS    = 4,
  parameter int IQ_DEPTH = 16,
  parameter int SEQ_W    = 8,
  localparam int CNT_W   = $clog2(IQ_DEPTH + 1)
) (
  input logic             clk,
  input logic             srst_n,
  input logic             squashing,
  input logic             cm_store,
  input logic [SEQ_W-1:0] cm_ns_seq,
  input logic [SLOTS-1:0] iq_put,
  input logic [SLOTS-1:0] iq_put_ns,
  input logic [SLOTS-1:0] ldq_put,
  input logic [SLOTS-1:0] stq_put,
  input logic [SLOTS-1:0] can_commit,
  input logic             rn_block,
  input logic [CNT_W-1:0] iq_free,
  input logic             lsq_store_commit,
  input logic             lsq_load_commit,
  input logic             iq_ns_release
);

  logic any_put;
  assign any_put = |{iq_put, iq_put_ns, ldq_put, stq_put, can_commit};

  assert_free_bound_R9: assert property (@(posedge clk) disable iff (!srst_n)
    iq_free <= CNT_W'(IQ_DEPTH));

  assert_free_drop_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (iq_free < $past(iq_free)) |-> $past(|{iq_put, iq_put_ns}));

  assert_squash_quiet_R2: assert property (@(posedge clk) disable iff (!srst_n)
    squashing |-> !any_put);

  assert_block_quiet_R10: assert property (@(posedge clk) disable iff (!srst_n)
    rn_block |-> !any_put);

  assert_cc_parked_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (can_commit & ~iq_put_ns) == '0);

  assert_commit_excl_R11: assert property (@(posedge clk) disable iff (!srst_n)
    !(lsq_store_commit && lsq_load_commit));

  assert_store_relay_R11: assert property (@(posedge clk) disable iff (!srst_n)
    cm_store |=> lsq_store_commit);

  assert_ns_release_R12: assert property (@(posedge clk) disable iff (!srst_n)
    (cm_ns_seq != '0) |=> iq_ns_release);

endmodule

bind dispatch_steer dispatch_steer_checks #(
  .SLOTS(SLOTS), .IQ_DEPTH(IQ_DEPTH), .SEQ_W(SEQ_W)
) u_checks (
  .clk              (clk),
  .srst_n           (srst_n),
  .squashing        (squashing),
  .cm_store         (cm_store),
  .cm_ns_seq        (cm_ns_seq),
  .iq_put           (iq_put),
  .iq_put_ns        (iq_put_ns),
  .ldq_put          (ldq_put),
  .stq_put          (stq_put),
  .can_commit       (can_commit),
  .rn_block         (rn_block),
  .iq_free          (iq_free),
  .lsq_store_commit (lsq_store_commit),
  .lsq_load_commit  (lsq_load_commit),
  .iq_ns_release    (iq_ns_release)
);

// File: tb/dispatch_steer_test.sv
module dispatch_steer_test;
  localparam int SLOTS = 4;
  localparam int DEPTH = 8;
  localparam int SEQ_W = 6;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [SLOTS-1:0] rn_valid = '0, rn_squashed = '0, rn_load = '0;
  logic [SLOTS-1:0] rn_store = '0, rn_nonspec = '0, rn_nop = '0;
  logic             squashing = 1'b0, cm_store = 1'b0, cm_load = 1'b0;
  logic [CNT_W-1:0] iq_drain = '0;
  logic [SEQ_W-1:0] cm_done_seq = '0, cm_ns_seq = '0;
  logic [SLOTS-1:0] iq_put, iq_put_ns, ldq_put, stq_put, can_commit;
  logic             rn_block, lsq_store_commit, lsq_load_commit, iq_ns_release;
  logic [CNT_W-1:0] iq_free;
  logic [SEQ_W-1:0] lsq_commit_seq, iq_ns_release_seq;

  dispatch_steer #(.SLOTS(SLOTS), .IQ_DEPTH(DEPTH), .SEQ_W(SEQ_W)) uut (
    .clk(clk), .rst_n(rst_n), .rn_valid(rn_valid), .rn_squashed(rn_squashed),
    .rn_load(rn_load), .rn_store(rn_store), .rn_nonspec(rn_nonspec), .rn_nop(rn_nop),
    .squashing(squashing), .iq_drain(iq_drain), .cm_store(cm_store), .cm_load(cm_load),
    .cm_done_seq(cm_done_seq), .cm_ns_seq(cm_ns_seq), .iq_put(iq_put),
    .iq_put_ns(iq_put_ns), .ldq_put(ldq_put), .stq_put(stq_put),
    .can_commit(can_commit), .rn_block(rn_block), .iq_free(iq_free),
    .lsq_store_commit(lsq_store_commit), .lsq_load_commit(lsq_load_commit),
    .lsq_commit_seq(lsq_commit_seq), .iq_ns_release(iq_ns_release),
    .iq_ns_release_seq(iq_ns_release_seq)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0, model_on = 1'b0;

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: occupancy and relay state as plain variables.
  int m_occ = 0, n_occ = 0;
  bit m_rs = 0, m_rl = 0, m_ns = 0, n_rs = 0, n_rl = 0, n_ns = 0;
  int m_rseq = 0, m_nsseq = 0, n_rseq = 0, n_nsseq = 0;

  always @(negedge clk) begin
    if (model_on) begin
      int e_iq, e_ns, e_ld, e_st, e_cc, need, taken, free;
      bit stop, acc, blk;
      e_iq = 0; e_ns = 0; e_ld = 0; e_st = 0; e_cc = 0; need = 0; stop = 0;
      for (int i = 0; i < SLOTS; i++) begin
        if (!rn_valid[i]) stop = 1;
        if (!stop && !rn_squashed[i]) begin
          if (rn_load[i]) begin e_ld |= 1 << i; e_iq |= 1 << i; need++; end
          else if (rn_store[i]) begin
            e_st |= 1 << i; e_ns |= 1 << i; e_cc |= 1 << i; need++;
          end else if (rn_nonspec[i]) begin e_ns |= 1 << i; e_cc |= 1 << i; need++; end
          else if (!rn_nop[i]) begin e_iq |= 1 << i; need++; end
        end
      end
      free = DEPTH - m_occ;
      acc  = !squashing && need <= free;
      blk  = rn_valid[0] && !acc;
      if (!acc) begin e_iq = 0; e_ns = 0; e_ld = 0; e_st = 0; e_cc = 0; end
      chk("R8 iq_put", int'(iq_put), e_iq);
      chk("R6 iq_put_ns", int'(iq_put_ns), e_ns);
      chk("R4 ldq_put", int'(ldq_put), e_ld);
      chk("R5 stq_put", int'(stq_put), e_st);
      chk("R5 can_commit", int'(can_commit), e_cc);
      chk("R10 rn_block", int'(rn_block), int'(blk));
      chk("R9 iq_free", int'(iq_free), free);
      chk("R11 store_commit", int'(lsq_store_commit), int'(m_rs));
      chk("R11 load_commit", int'(lsq_load_commit), int'(m_rl));
      if (m_rs || m_rl) chk("R11 commit_seq", int'(lsq_commit_seq), m_rseq);
      chk("R12 ns_release", int'(iq_ns_release), int'(m_ns));
      if (m_ns) chk("R12 ns_seq", int'(iq_ns_release_seq), m_nsseq);
      taken = (int'(iq_drain) > m_occ) ? m_occ : int'(iq_drain);
      n_occ = m_occ - taken + (acc ? need : 0);
      n_rs = cm_store; n_rl = cm_load && !cm_store;
      n_rseq = (cm_store || cm_load) ? int'(cm_done_seq) : m_rseq;
      n_ns = (cm_ns_seq != 0);
      n_nsseq = n_ns ? int'(cm_ns_seq) : m_nsseq;
    end
  end

  always @(posedge clk) begin
    if (model_on) begin
      m_occ <= n_occ; m_rs <= n_rs; m_rl <= n_rl; m_rseq <= n_rseq;
      m_ns <= n_ns; m_nsseq <= n_nsseq;
    end
  end

  task automatic idle();
    rn_valid = '0; rn_squashed = '0; rn_load = '0; rn_store = '0;
    rn_nonspec = '0; rn_nop = '0; squashing = 0; iq_drain = '0;
    cm_store = 0; cm_load = 0; cm_done_seq = '0; cm_ns_seq = '0;
  endtask

  task automatic next();
    @(posedge clk); #1;
  endtask

  task automatic flush();
    next(); idle(); iq_drain = CNT_W'(DEPTH);
  endtask

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R9 reset free", int'(iq_free), DEPTH);
    chk("R10 reset block", int'(rn_block), 0);
    chk("R11 reset commit", int'(lsq_store_commit | lsq_load_commit), 0);
    chk("R12 reset release", int'(iq_ns_release), 0);
    next(); model_on = 1'b1;

    // R1: gap at slot 1 ends the group.
    next(); idle(); rn_valid = 4'b1101;
    @(negedge clk); chk("R1 gap stops scan", int'(iq_put), 1);
    // R13 / R8: full plain group, slot-ordered strobes.
    flush(); next(); idle(); rn_valid = 4'b1111;
    @(negedge clk); chk("R13 slot order", int'(iq_put), 15);
    // Mixed classes: R4 R5 R6 R7.
    flush(); next(); idle(); rn_valid = 4'b1111;
    rn_load = 4'b0001; rn_store = 4'b0010; rn_nonspec = 4'b0100; rn_nop = 4'b1000;
    @(negedge clk);
    chk("R4 load", int'(ldq_put | iq_put), 1);
    chk("R5 store", int'(stq_put), 2);
    chk("R6 nonspec", int'(iq_put_ns), 6);
    chk("R7 nop", int'((iq_put | iq_put_ns) >> 3), 0);
    // R3: squashed load dropped.
    flush(); next(); idle(); rn_valid = 4'b0001; rn_load = 4'b0001; rn_squashed = 4'b0001;
    @(negedge clk); chk("R3 squashed dropped", int'(ldq_put | iq_put), 0);
    next(); idle();
    @(negedge clk); chk("R3 no entry used", int'(iq_free), DEPTH);
    // R2: squashing holds the group.
    next(); idle(); rn_valid = 4'b0001; squashing = 1;
    @(negedge clk); chk("R2 squash block", int'(rn_block), 1);
    chk("R2 squash quiet", int'(iq_put), 0);
    // R10: fill the queue then overflow.
    flush(); next(); idle(); rn_valid = 4'b1111;
    next(); rn_valid = 4'b1111;
    next(); rn_valid = 4'b0001;
    @(negedge clk); chk("R10 full block", int'(rn_block), 1);
    chk("R9 zero free", int'(iq_free), 0);
    // R11: store wins over load.
    flush(); next(); idle(); cm_store = 1; cm_load = 1; cm_done_seq = 5;
    next(); idle(); @(negedge clk);
    chk("R11 store relay", int'(lsq_store_commit), 1);
    chk("R11 load suppressed", int'(lsq_load_commit), 0);
    chk("R11 seq", int'(lsq_commit_seq), 5);
    next(); cm_load = 1; cm_done_seq = 9;
    next(); idle(); @(negedge clk);
    chk("R11 load relay", int'(lsq_load_commit), 1);
    chk("R11 load seq", int'(lsq_commit_seq), 9);
    // R12: zero releases nothing, non-zero schedules.
    @(negedge clk); chk("R12 zero no release", int'(iq_ns_release), 0);
    next(); cm_ns_seq = 7;
    next(); idle(); @(negedge clk);
    chk("R12 release", int'(iq_ns_release), 1);
    chk("R12 release seq", int'(iq_ns_release_seq), 7);

    // Random traffic, compared every cycle by the model.
    for (int c = 0; c < 4000; c++) begin
      next();
      rn_valid    = ($urandom % 3 == 0) ? 4'b1111 : SLOTS'($urandom);
      rn_squashed = SLOTS'($urandom & $urandom);
      rn_load     = SLOTS'($urandom & $urandom);
      rn_store    = SLOTS'($urandom & $urandom);
      rn_nonspec  = SLOTS'($urandom & $urandom);
      rn_nop      = SLOTS'($urandom & $urandom);
      squashing   = ($urandom % 10 == 0);
      iq_drain    = CNT_W'($urandom % 4);
      cm_store    = ($urandom % 4 == 0);
      cm_load     = ($urandom % 3 == 0);
      cm_done_seq = SEQ_W'($urandom);
      cm_ns_seq   = ($urandom % 2 == 0) ? '0 : SEQ_W'($urandom);
    end
    next(); idle();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule